// File: doc/BRIEF.md
# Daisy-Chain SPI Frame Handler

This block is the peripheral-side frame logic for one device in a chain of SPI peripherals that share a single chip select and pass data from each device's SDO to the next device's SDI. It runs on a fast system clock. SCLK, SDI and the active-low chip select arrive already synchronised. The block watches these for edges, shifts bits in on rising SCLK, and drives SDO on falling SCLK.

Each frame opens with the device's own status byte. After that, every received byte is sent out again exactly one byte time later, so the whole stream ripples down the chain. The device counts the bytes that arrive before the first header byte to learn its own position. It reads the device count from that header and picks its own command and data bytes out of the two slot groups that follow. When chip select rises, a well-formed frame releases the captured pair with a one-cycle strobe and may pulse a global fault-clear. A malformed frame raises an error flag and discards the capture.

Top module: `spi_chain_node`

## Requirements
- R1: SDO carries `stat_byte` during the first byte time of a frame. During byte time k+1 it carries the byte received in byte time k, unchanged, including pass bytes (top two bits 11). Bits go MSB first. SDI is sampled on rising SCLK, and SDO changes only on falling SCLK or on the falling edge of chip select.
- R2: A byte whose top two bits are 10 is a header byte. The first header byte sets the device count from its low six bits. The number of bytes received before it, plus one, is the device's position p.
- R3: With device count n, the command group takes n bytes after the second header byte, and the data group takes the next n bytes. The device captures the byte at index n-p of each group (index 0 first). On a well-formed frame, a rising chip select copies them to `cmd_q` and `dat_q` and pulses `rx_valid` for one cycle.
- R4: If the device's own command slot holds a byte whose top two bits are 11, it is not taken. No `rx_valid` pulse follows, and `cmd_q`/`dat_q` keep their values.
- R5: A device count of 0 in the first header sets `spi_err` at the rise of chip select, with no `rx_valid`.
- R6: If chip select rises after a total byte count other than (p-1)+2n+2, or in the middle of a byte, `spi_err` is set. The capture is discarded: there is no `rx_valid`, and `cmd_q`/`dat_q` do not change.
- R7: Bit 5 of the second header byte requests a global fault clear. On a well-formed frame, `clr_fault` pulses for one cycle at the rise of chip select. Bits 4..0 of that byte have no effect.
- R8: `spi_err` holds from the rise of chip select until the next fall of chip select, which clears it.
- R9: After reset `sdo`, `cmd_q`, `dat_q`, `rx_valid`, `clr_fault` and `spi_err` are all 0.
- R10: The frame is malformed and sets `spi_err` if the second header byte does not start with 10, or if p is larger than n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Synchronised serial clock |
| sdi | input | 1 | Synchronised serial data in |
| cs_n | input | 1 | Synchronised active-low chip select |
| stat_byte | input | 8 | Own status byte, loaded at the fall of chip select |
| sdo | output | 1 | Serial data out |
| cmd_q | output | 8 | Last accepted command byte |
| dat_q | output | 8 | Last accepted data byte |
| rx_valid | output | 1 | One-cycle strobe when a new command/data pair is accepted |
| clr_fault | output | 1 | One-cycle global fault-clear request |
| spi_err | output | 1 | Frame error flag |

## Verification
Well-formed frames are sent with the device first, last and in the middle of chains of one, three, four, five and 63 devices. This tells slot arithmetic that is off by one, or mirrored, apart from correct selection. A frame with a pass byte in the device's own command slot tells the pass-byte rule apart from plain capture. Frames with a zero count, a bad second header, a position beyond the count, an extra byte and a trailing partial byte each exercise one separate error path, and every frame's SDO stream is compared byte for byte against the one-byte-delayed input. Clear-fault frames with the spare bits set and cleared show that only bit 5 matters.

// File: rtl/spi_chain_node.sv
module spi_chain_node (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk,
  input  logic       sdi,
  input  logic       cs_n,
  input  logic [7:0] stat_byte,
  output logic       sdo,
  output logic [7:0] cmd_q,
  output logic [7:0] dat_q,
  output logic       rx_valid,
  output logic       clr_fault,
  output logic       spi_err
);
  localparam int BW = 8;
  localparam int NW = 6;

  logic          sclk_d, cs_d;
  logic [BW-2:0] rx_sh;
  logic [2:0]    bit_cnt, fall_cnt;
  logic [BW-1:0] byte_cnt, hdr_at;
  logic [BW-1:0] tx, nxt;
  logic          hdr_seen, hdr2_bad, clr_req;
  logic [NW-1:0] n_dev;
  logic [BW-1:0] cmd_buf, dat_buf;
  logic          cmd_got, dat_got;

  wire s_rise  = sclk & ~sclk_d & ~cs_n;
  wire s_fall  = ~sclk & sclk_d & ~cs_n;
  wire cs_fall = ~cs_n & cs_d;
  wire cs_rise = cs_n & ~cs_d;

  wire [BW-1:0] rx_byte = {rx_sh, sdi};
  wire [BW-1:0] n_ext   = {{(BW-NW){1'b0}}, n_dev};
  wire [BW-1:0] rel     = byte_cnt - hdr_at;
  wire [BW-1:0] slot    = n_ext - hdr_at - 8'd1;
  wire [BW-1:0] cmd_rel = slot + 8'd2;
  wire [BW-1:0] dat_rel = slot + 8'd2 + n_ext;
  wire          pos_ok  = hdr_at < n_ext;
  wire [BW:0]   total   = {1'b0, hdr_at} + {2'b00, n_dev, 1'b0} + 9'd2;

  wire frame_ok = hdr_seen && (n_dev != '0) && !hdr2_bad && pos_ok &&
                  (bit_cnt == 3'd0) && ({1'b0, byte_cnt} == total);

  assign sdo = tx[BW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      cs_d   <= 1'b1;
    end else begin
      sclk_d <= sclk;
      cs_d   <= cs_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sh    <= '0;
      bit_cnt  <= '0;
      byte_cnt <= '0;
      hdr_at   <= '0;
      hdr_seen <= 1'b0;
      hdr2_bad <= 1'b0;
      clr_req  <= 1'b0;
      n_dev    <= '0;
      cmd_buf  <= '0;
      dat_buf  <= '0;
      cmd_got  <= 1'b0;
      dat_got  <= 1'b0;
      nxt      <= '0;
    end else if (cs_fall) begin
      bit_cnt  <= '0;
      byte_cnt <= '0;
      hdr_at   <= '0;
      hdr_seen <= 1'b0;
      hdr2_bad <= 1'b0;
      clr_req  <= 1'b0;
      n_dev    <= '0;
      cmd_got  <= 1'b0;
      dat_got  <= 1'b0;
    end else if (s_rise) begin
      rx_sh   <= rx_byte[BW-2:0];
      bit_cnt <= bit_cnt + 3'd1;
      if (bit_cnt == 3'd7) begin
        nxt <= rx_byte;
        if (byte_cnt != '1) byte_cnt <= byte_cnt + 8'd1;
        if (!hdr_seen) begin
          if (rx_byte[7:6] == 2'b10) begin
            hdr_seen <= 1'b1;
            hdr_at   <= byte_cnt;
            n_dev    <= rx_byte[NW-1:0];
          end
        end else begin
          if (rel == 8'd1) begin
            hdr2_bad <= rx_byte[7:6] != 2'b10;
            clr_req  <= rx_byte[5];
          end
          if (pos_ok && rel == cmd_rel && rx_byte[7:6] != 2'b11) begin
            cmd_buf <= rx_byte;
            cmd_got <= 1'b1;
          end
          if (pos_ok && rel == dat_rel) begin
            dat_buf <= rx_byte;
            dat_got <= 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx       <= '0;
      fall_cnt <= '0;
    end else if (cs_fall) begin
      tx       <= stat_byte;
      fall_cnt <= '0;
    end else if (s_fall) begin
      fall_cnt <= fall_cnt + 3'd1;
      tx       <= (fall_cnt == 3'd7) ? nxt : {tx[BW-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q     <= '0;
      dat_q     <= '0;
      rx_valid  <= 1'b0;
      clr_fault <= 1'b0;
      spi_err   <= 1'b0;
    end else begin
      rx_valid  <= 1'b0;
      clr_fault <= 1'b0;
      if (cs_fall) spi_err <= 1'b0;
      if (cs_rise) begin
        spi_err   <= !frame_ok;
        clr_fault <= frame_ok && clr_req;
        if (frame_ok && cmd_got && dat_got) begin
          cmd_q    <= cmd_buf;
          dat_q    <= dat_buf;
          rx_valid <= 1'b1;
        end
      end
    end
  end
endmodule

module spi_chain_node_chk (
  input logic clk,
  input logic rst_n,
  input logic sclk,
  input logic cs_n,
  input logic sdo,
  input logic rx_valid,
  input logic clr_fault,
  input logic spi_err
);
  a_r1_sdo_moves_on_edges: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo) |-> (($past(sclk, 2) && !$past(sclk)) || ($past(cs_n, 2) && !$past(cs_n))));
  a_r3_valid_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  a_r3_valid_at_cs_rise: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> ($past(cs_n) && !$past(cs_n, 2)));
  a_r6_no_valid_with_err: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !spi_err);
  a_r7_clr_at_cs_rise: assert property (@(posedge clk) disable iff (!rst_n)
    clr_fault |-> ($past(cs_n) && !$past(cs_n, 2) && !spi_err));
  a_r8_err_clears_at_cs_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_err) |-> (!$past(cs_n) && $past(cs_n, 2)));
  a_r9_reset_quiet: assert property (@(posedge clk)
    $rose(rst_n) |-> (!rx_valid && !clr_fault && !spi_err && !sdo));
endmodule

bind spi_chain_node spi_chain_node_chk i_chk (
  .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdo(sdo),
  .rx_valid(rx_valid), .clr_fault(clr_fault), .spi_err(spi_err)
);

// File: tb/test_spi_chain_node.sv
module test_spi_chain_node;
  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, sdi = 1'b0, cs_n = 1'b1;
  logic [7:0] stat_byte = 8'h00;
  logic sdo, rx_valid, clr_fault, spi_err;
  logic [7:0] cmd_q, dat_q;

  int checks = 0, errors = 0;
  int vcnt = 0, ccnt = 0;
  logic [7:0] fb[$];
  logic [7:0] expq[$];
  logic [7:0] mon_sh;
  int mon_bits = 0;

  always #2 clk = ~clk;

  spi_chain_node i_spi_chain_node (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdi(sdi), .cs_n(cs_n),
    .stat_byte(stat_byte), .sdo(sdo), .cmd_q(cmd_q), .dat_q(dat_q),
    .rx_valid(rx_valid), .clr_fault(clr_fault), .spi_err(spi_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (rx_valid) vcnt++;
    if (clr_fault) ccnt++;
  end

  always @(negedge cs_n) mon_bits = 0;

  always @(posedge sclk) begin
    if (!cs_n) begin
      mon_sh = {mon_sh[6:0], sdo};
      mon_bits++;
      if (mon_bits == 8) begin
        mon_bits = 0;
        if (expq.size() == 0) check("R1 unexpected sdo byte", {24'd0, mon_sh}, 32'hFFFF);
        else check("R1 sdo byte", {24'd0, mon_sh}, {24'd0, expq.pop_front()});
      end
    end
  end

  function automatic void build(int p, int n, bit clr, logic [4:0] spare);
    fb.delete();
    for (int i = 0; i < p - 1; i++) fb.push_back(8'hC0 | 8'(i & 63));
    fb.push_back(8'h80 | 8'(n & 63));
    fb.push_back({2'b10, clr, spare});
    for (int k = 0; k < n; k++) fb.push_back(8'h10 + 8'(k));
    for (int k = 0; k < n; k++) fb.push_back(8'hA0 + 8'(k));
  endfunction

  task automatic send_bit(input logic b);
    sdi = b;
    repeat (4) @(negedge clk);
    sclk = 1'b1;
    repeat (4) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic run_frame(input logic [7:0] stat, input int extra_bits);
    stat_byte = stat;
    expq.push_back(stat);
    for (int i = 0; i + 1 < fb.size(); i++) expq.push_back(fb[i]);
    @(negedge clk);
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    foreach (fb[i]) for (int b = 7; b >= 0; b--) send_bit(fb[i][b]);
    for (int b = 0; b < extra_bits; b++) send_bit(1'b0);
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic expect_frame(input string req, input int v0, input int c0, input int dv,
                              input int dc, input logic err, input logic [7:0] ec,
                              input logic [7:0] ed);
    check({req, " rx_valid count"}, vcnt - v0, dv);
    check({req, " clr_fault count"}, ccnt - c0, dc);
    check({req, " spi_err"}, spi_err, err);
    check({req, " cmd_q"}, cmd_q, ec);
    check({req, " dat_q"}, dat_q, ed);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual running expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int v0, c0;
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 sdo", sdo, 0);
    check("R9 rx_valid", rx_valid, 0);
    check("R9 spi_err", spi_err, 0);
    check("R9 cmd_q", cmd_q, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2 R3: first of three, slot 2
    v0 = vcnt; c0 = ccnt; build(1, 3, 0, 5'h00); run_frame(8'hE1, 0);
    expect_frame("R3 p1 n3", v0, c0, 1, 0, 0, 8'h12, 8'hA2);
    // R2 R3: last of three, slot 0
    v0 = vcnt; c0 = ccnt; build(3, 3, 0, 5'h00); run_frame(8'hE2, 0);
    expect_frame("R2 p3 n3", v0, c0, 1, 0, 0, 8'h10, 8'hA0);
    // R7: clear requested, spares all ones
    v0 = vcnt; c0 = ccnt; build(1, 1, 1, 5'h1F); run_frame(8'hE3, 0);
    expect_frame("R7 clr set", v0, c0, 1, 1, 0, 8'h10, 8'hA0);
    // R7: spares set, clear bit off
    v0 = vcnt; c0 = ccnt; build(2, 5, 0, 5'h15); run_frame(8'hE4, 0);
    expect_frame("R7 spare only", v0, c0, 1, 0, 0, 8'h13, 8'hA3);
    // R4: pass byte in own command slot (p=2, n=4, slot 2 at index 1+2+2)
    v0 = vcnt; c0 = ccnt; build(2, 4, 0, 5'h00); fb[5] = 8'hC7; run_frame(8'hE5, 0);
    expect_frame("R4 pass slot", v0, c0, 0, 0, 0, 8'h13, 8'hA3);
    // R5: zero device count
    v0 = vcnt; c0 = ccnt; build(1, 0, 1, 5'h00); run_frame(8'hE6, 0);
    expect_frame("R5 zero count", v0, c0, 0, 0, 1, 8'h13, 8'hA3);
    // R8: error cleared at next chip select fall
    @(negedge clk); cs_n = 1'b0;
    repeat (4) @(negedge clk);
    check("R8 spi_err after cs fall", spi_err, 0);
    cs_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R8 spi_err after empty frame", spi_err, 1);
    // R6: one extra byte
    v0 = vcnt; c0 = ccnt; build(1, 2, 1, 5'h00); fb.push_back(8'h55); run_frame(8'hE7, 0);
    expect_frame("R6 extra byte", v0, c0, 0, 0, 1, 8'h13, 8'hA3);
    // R6: trailing partial byte
    v0 = vcnt; c0 = ccnt; build(2, 2, 0, 5'h00); run_frame(8'hE8, 3);
    expect_frame("R6 partial byte", v0, c0, 0, 0, 1, 8'h13, 8'hA3);
    // R10: position beyond count
    v0 = vcnt; c0 = ccnt; build(3, 2, 0, 5'h00); run_frame(8'hE9, 0);
    expect_frame("R10 pos>n", v0, c0, 0, 0, 1, 8'h13, 8'hA3);
    // R10: second header malformed
    v0 = vcnt; c0 = ccnt; build(1, 2, 1, 5'h00); fb[1] = 8'h40; run_frame(8'hEA, 0);
    expect_frame("R10 bad hdr2", v0, c0, 0, 0, 1, 8'h13, 8'hA3);
    // R3: long chain, position 40 of 63 -> slot 23
    v0 = vcnt; c0 = ccnt; build(40, 63, 0, 5'h0A); run_frame(8'hEB, 0);
    expect_frame("R3 p40 n63", v0, c0, 1, 0, 0, 8'h27, 8'hB7);
    check("R1 all sdo bytes seen", expq.size(), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule